// File: doc/BRIEF.md
# ECC Read-Modify-Write Write Path

This block is the single shared protection stage between a multi-port memory datapath and a DDR PHY. It covers each 64-bit word with 8 check bits of an extended Hamming (72,64) code, which corrects any single-bit error and detects any double-bit error. Encoding and checking are done on the single-data-rate side of the PHY.

When write protection is on, any write becomes a read-modify-write, even one that enables every byte. The block reads the target word and corrects it. It keeps the corrected word in a small buffer FIFO. It then takes the new bytes where their enables are set and the buffered bytes everywhere else. Finally it re-encodes the merged word and writes all of it with no mask. Plain reads are decoded and corrected, and come back with single-error and double-error flags.

A small register set holds the read and write protection enables, two interrupt enables and two saturating error counters. The interrupt enables let software keep the interrupt line low while memory with uninitialised check bits is being scrubbed.

Top module: `ecc_rmw_path`

## Requirements
- R1: While write protection is enabled, every accepted write, whatever its byte enables (8'hFF included), is carried out in two steps. First comes a memory read of the request address. Then comes a memory write to the same address with `mem_cmd_mask` = 8'h00. `req_ready` stays low from acceptance until that write command has been taken.
- R2: In the written word, byte lane L (bits 8L+7..8L) comes from `req_wdata` when `req_be[L]` is 1. Otherwise it comes from the corrected read word.
- R3: The corrected read word is held in an internal buffer FIFO until the merge uses it. The check bits sent with the written word are the code of the merged word.
- R4: The code works as follows. Data bit k takes the (k+1)-th position among 1..71 that is not a power of two, so data bit 0 sits at position 3. Check bit i (i = 0..6) is the XOR of the data bits whose position has bit i set. Check bit 7 makes the parity of all 72 bits even.
- R5: A read with read protection enabled returns its response exactly one cycle after `mem_rd_valid`. A single-bit error, in data or in check bits, is corrected and sets `rsp_sbe`. A nonzero syndrome with even overall parity sets `rsp_dbe` and returns the data unchanged. The two flags are never set together.
- R6: With read protection disabled, reads return raw memory data, both flags read 0 and the counters do not change.
- R7: With write protection disabled, a write issues a single memory write of `req_wdata` with `mem_cmd_mask` = ~`req_be` and no read.
- R8: The single-error and double-error counters are 8-bit and saturate at 255. Each one increments once per error found on a protected read or during a read-modify-write. Writing 1s to a counter's register clears those bits.
- R9: `irq` = (single count != 0 AND single interrupt enable) OR (double count != 0 AND double interrupt enable). With both enables at 0, `irq` stays 0 while errors are counted.
- R10: An uncorrectable error during a read-modify-write still completes the write. The masked-off lanes carry the uncorrected read bytes, and the double-error counter increments.
- R11: There are four registers. Address 0 is control: bit 0 read protection, bit 1 write protection, bit 2 single-error interrupt enable, bit 3 double-error interrupt enable, reset value 0. Address 1 is the single-error count, address 2 is the double-error count, and address 3 reads 0.
- R12: While `mem_cmd_valid` is high and `mem_cmd_ready` is low, the command holds valid, address and direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single-data-rate clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Port request valid |
| req_ready | output | 1 | Request accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address |
| req_wdata | input | 64 | Write data |
| req_be | input | 8 | Byte enables for the write |
| rsp_valid | output | 1 | Read response strobe |
| rsp_rdata | output | 64 | Read data, corrected when enabled |
| rsp_sbe | output | 1 | Corrected single-bit error in this response |
| rsp_dbe | output | 1 | Uncorrectable error in this response |
| mem_cmd_valid | output | 1 | Memory command valid |
| mem_cmd_ready | input | 1 | Memory command taken |
| mem_cmd_write | output | 1 | Memory command direction |
| mem_cmd_addr | output | AW | Memory command address |
| mem_cmd_wdata | output | 64 | Memory write data |
| mem_cmd_ecc | output | 8 | Memory write check bits |
| mem_cmd_mask | output | 8 | Memory write byte mask, 1 = lane not written |
| mem_rd_valid | input | 1 | Memory read data strobe |
| mem_rd_data | input | 64 | Memory read data |
| mem_rd_ecc | input | 8 | Memory read check bits |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register address |
| csr_wdata | input | 8 | Register write data |
| csr_rdata | output | 8 | Register read data |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case is an uncorrectable error that arrives in the middle of a read-modify-write. Its effect shows only as the raw flipped bits in the masked-off lanes of the following write and as a counter change. The bench memory model therefore XORs a chosen error pattern into the word it returns. It then compares the next write command, lane by lane, with a merge built from the flipped word. Command stalls are produced by holding `mem_cmd_ready` low for a fixed number of cycles at each command. This shows that the command holds and that no new request gets in between the read and the write.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int DATA_W    = 64;
  localparam int HAM_W     = 7;
  localparam int CHK_W     = HAM_W + 1;
  localparam int LANES     = DATA_W / 8;
  localparam int CODE_LAST = DATA_W + HAM_W;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD_ISSUE,
    ST_RD_WAIT,
    ST_WR_ISSUE,
    ST_WR_PASS
  } rmw_state_e;

  // Hamming position of data bit k: k-th non power-of-two in 1..CODE_LAST
  function automatic int data_pos(input int k);
    int n;
    int res;
    n   = 0;
    res = 0;
    for (int p = 1; p <= CODE_LAST; p++) begin
      if ((p & (p - 1)) != 0) begin
        if (n == k) res = p;
        n++;
      end
    end
    return res;
  endfunction

  // Data bits that feed Hamming check bit i
  function automatic logic [DATA_W-1:0] chk_mask(input int i);
    logic [DATA_W-1:0] m;
    int pos;
    m = '0;
    for (int k = 0; k < DATA_W; k++) begin
      pos  = data_pos(k);
      m[k] = pos[i];
    end
    return m;
  endfunction
endpackage

// File: rtl/ecc_rst_sync.sv
module ecc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/ecc_secded_enc.sv
module ecc_secded_enc
  import ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  output logic [CHK_W-1:0]  chk_o
);
  logic [HAM_W-1:0] ham;

  for (genvar i = 0; i < HAM_W; i++) begin : g_ham
    localparam logic [DATA_W-1:0] SEL = chk_mask(i);
    assign ham[i] = ^(data_i & SEL);
  end

  assign chk_o = {(^data_i) ^ (^ham), ham};
endmodule

// File: rtl/ecc_secded_dec.sv
module ecc_secded_dec
  import ecc_pkg::*;
(
  input  logic [DATA_W-1:0] data_i,
  input  logic [CHK_W-1:0]  chk_i,
  output logic [DATA_W-1:0] data_o,
  output logic              sbe_o,
  output logic              dbe_o
);
  logic [CHK_W-1:0] recalc;
  logic [HAM_W-1:0] syn;
  logic             odd;

  ecc_secded_enc u_enc (
    .data_i (data_i),
    .chk_o  (recalc)
  );

  assign syn   = chk_i[HAM_W-1:0] ^ recalc[HAM_W-1:0];
  // parity of received word = regenerated overall bit ^ regenerated ham ^ received bits
  assign odd   = recalc[CHK_W-1] ^ (^recalc[HAM_W-1:0]) ^ (^chk_i);
  assign sbe_o = odd && (syn <= HAM_W'(CODE_LAST));
  assign dbe_o = !sbe_o && (odd || (syn != '0));

  for (genvar k = 0; k < DATA_W; k++) begin : g_fix
    localparam int POS = data_pos(k);
    assign data_o[k] = data_i[k] ^ (sbe_o && (syn == HAM_W'(POS)));
  end
endmodule

// File: rtl/ecc_rd_fifo.sv
module ecc_rd_fifo #(
  parameter int WIDTH = 64,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [WIDTH-1:0] push_data,
  input  logic             pop,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [WIDTH-1:0] store_q [DEPTH];
  logic [PW-1:0]    wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]    cnt_q, cnt_d;
  logic             do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == FULL_CNT);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign head    = store_q[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (do_push) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    if (do_pop)  rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      cnt_q    <= cnt_d;
    end
  end

  for (genvar e = 0; e < DEPTH; e++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  store_q[e] <= '0;
      else if (do_push && (wr_ptr_q == PW'(e)))    store_q[e] <= push_data;
    end
  end

  AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (!rst_n) push |-> !full);  // R3
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n) pop |-> !empty);  // R3
endmodule

// File: rtl/ecc_byte_merge.sv
module ecc_byte_merge
  import ecc_pkg::*;
(
  input  logic [DATA_W-1:0] old_i,
  input  logic [DATA_W-1:0] new_i,
  input  logic [LANES-1:0]  be_i,
  output logic [DATA_W-1:0] merged_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged_o[8*l +: 8] = be_i[l] ? new_i[8*l +: 8] : old_i[8*l +: 8];
  end
endmodule

// File: rtl/ecc_csr.sv
module ecc_csr #(
  parameter int CNT_W = 8,
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_we,
  input  logic [1:0]       csr_addr,
  input  logic [REG_W-1:0] csr_wdata,
  output logic [REG_W-1:0] csr_rdata,
  input  logic             sbe_evt,
  input  logic             dbe_evt,
  output logic             rd_en,
  output logic             wr_en,
  output logic             irq
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [1:0] A_CTRL = 2'd0;
  localparam logic [1:0] A_SBE  = 2'd1;
  localparam logic [1:0] A_DBE  = 2'd2;

  logic [3:0]       ctrl_q, ctrl_d;
  logic [CNT_W-1:0] sbe_cnt_q, sbe_cnt_d, dbe_cnt_q, dbe_cnt_d;
  logic             sbe_ie, dbe_ie, clr_sbe, clr_dbe;

  assign rd_en   = ctrl_q[0];
  assign wr_en   = ctrl_q[1];
  assign sbe_ie  = ctrl_q[2];
  assign dbe_ie  = ctrl_q[3];
  assign clr_sbe = csr_we && (csr_addr == A_SBE);
  assign clr_dbe = csr_we && (csr_addr == A_DBE);

  always_comb begin
    ctrl_d    = ctrl_q;
    sbe_cnt_d = sbe_cnt_q;
    dbe_cnt_d = dbe_cnt_q;
    if (csr_we && (csr_addr == A_CTRL)) ctrl_d = csr_wdata[3:0];
    if (sbe_evt && (sbe_cnt_q != CNT_MAX)) sbe_cnt_d = sbe_cnt_q + 1'b1;
    if (dbe_evt && (dbe_cnt_q != CNT_MAX)) dbe_cnt_d = dbe_cnt_q + 1'b1;
    if (clr_sbe) sbe_cnt_d = sbe_cnt_d & ~csr_wdata[CNT_W-1:0];
    if (clr_dbe) dbe_cnt_d = dbe_cnt_d & ~csr_wdata[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      sbe_cnt_q <= '0;
      dbe_cnt_q <= '0;
    end else begin
      ctrl_q    <= ctrl_d;
      sbe_cnt_q <= sbe_cnt_d;
      dbe_cnt_q <= dbe_cnt_d;
    end
  end

  always_comb begin
    case (csr_addr)
      A_CTRL:  csr_rdata = REG_W'(ctrl_q);
      A_SBE:   csr_rdata = REG_W'(sbe_cnt_q);
      A_DBE:   csr_rdata = REG_W'(dbe_cnt_q);
      default: csr_rdata = '0;
    endcase
  end

  assign irq = ((sbe_cnt_q != '0) && sbe_ie) || ((dbe_cnt_q != '0) && dbe_ie);

  AST_SBE_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (sbe_cnt_q == CNT_MAX && !clr_sbe) |=> sbe_cnt_q == CNT_MAX);  // R8
  AST_DBE_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (dbe_cnt_q == CNT_MAX && !clr_dbe) |=> dbe_cnt_q == CNT_MAX);  // R8
  AST_IRQ_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!sbe_ie && !dbe_ie) |-> !irq);  // R9
endmodule

// File: rtl/ecc_rmw_path.sv
module ecc_rmw_path
  import ecc_pkg::*;
#(
  parameter int AW        = 16,
  parameter int BUF_DEPTH = 2,
  parameter int CNT_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [AW-1:0]     req_addr,
  input  logic [63:0]       req_wdata,
  input  logic [7:0]        req_be,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_sbe,
  output logic              rsp_dbe,
  output logic              mem_cmd_valid,
  input  logic              mem_cmd_ready,
  output logic              mem_cmd_write,
  output logic [AW-1:0]     mem_cmd_addr,
  output logic [63:0]       mem_cmd_wdata,
  output logic [7:0]        mem_cmd_ecc,
  output logic [7:0]        mem_cmd_mask,
  input  logic              mem_rd_valid,
  input  logic [63:0]       mem_rd_data,
  input  logic [7:0]        mem_rd_ecc,
  input  logic              csr_we,
  input  logic [1:0]        csr_addr,
  input  logic [7:0]        csr_wdata,
  output logic [7:0]        csr_rdata,
  output logic              irq
);
  logic rst_n_s;
  rmw_state_e state_q, state_d;

  logic [AW-1:0]     addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [LANES-1:0]  be_q;
  logic              rmw_q;
  logic              accept, rd_en, wr_en;

  logic [DATA_W-1:0] dec_data, buf_head, merged, enc_in;
  logic              dec_sbe, dec_dbe, buf_empty, buf_full;
  logic [CHK_W-1:0]  enc_chk;
  logic              rd_back, buf_push, buf_pop, dec_evt;

  logic              rsp_valid_q, rsp_valid_d;
  logic [DATA_W-1:0] rsp_data_q;
  logic              rsp_sbe_q, rsp_dbe_q;

  ecc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  ecc_csr #(.CNT_W(CNT_W), .REG_W(8)) u_csr (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .csr_we    (csr_we),
    .csr_addr  (csr_addr),
    .csr_wdata (csr_wdata),
    .csr_rdata (csr_rdata),
    .sbe_evt   (dec_evt && dec_sbe),
    .dbe_evt   (dec_evt && dec_dbe),
    .rd_en     (rd_en),
    .wr_en     (wr_en),
    .irq       (irq)
  );

  ecc_secded_dec u_dec (
    .data_i (mem_rd_data),
    .chk_i  (mem_rd_ecc),
    .data_o (dec_data),
    .sbe_o  (dec_sbe),
    .dbe_o  (dec_dbe)
  );

  ecc_rd_fifo #(.WIDTH(DATA_W), .DEPTH(BUF_DEPTH)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .push      (buf_push),
    .push_data (dec_data),
    .pop       (buf_pop),
    .head      (buf_head),
    .empty     (buf_empty),
    .full      (buf_full)
  );

  ecc_byte_merge u_merge (
    .old_i    (buf_head),
    .new_i    (wdata_q),
    .be_i     (be_q),
    .merged_o (merged)
  );

  ecc_secded_enc u_enc (
    .data_i (enc_in),
    .chk_o  (enc_chk)
  );

  // ---------------- control ----------------
  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign rd_back   = (state_q == ST_RD_WAIT) && mem_rd_valid;
  assign buf_push  = rd_back && rmw_q;
  assign buf_pop   = (state_q == ST_WR_ISSUE) && mem_cmd_ready;
  assign dec_evt   = rd_back && (rmw_q || rd_en);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:     if (req_valid) state_d = (req_write && !wr_en) ? ST_WR_PASS : ST_RD_ISSUE;
      ST_RD_ISSUE: if (mem_cmd_ready) state_d = ST_RD_WAIT;
      ST_RD_WAIT:  if (mem_rd_valid) state_d = rmw_q ? ST_WR_ISSUE : ST_IDLE;
      ST_WR_ISSUE: if (mem_cmd_ready) state_d = ST_IDLE;
      ST_WR_PASS:  if (mem_cmd_ready) state_d = ST_IDLE;
      default:     state_d = ST_IDLE;
    endcase
  end

  assign rsp_valid_d = rd_back && !rmw_q;

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q     <= ST_IDLE;
      addr_q      <= '0;
      wdata_q     <= '0;
      be_q        <= '0;
      rmw_q       <= 1'b0;
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
      rsp_sbe_q   <= 1'b0;
      rsp_dbe_q   <= 1'b0;
    end else begin
      state_q     <= state_d;
      rsp_valid_q <= rsp_valid_d;
      if (accept) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
        be_q    <= req_be;
        rmw_q   <= req_write && wr_en;
      end
      if (rsp_valid_d) begin
        rsp_data_q <= rd_en ? dec_data : mem_rd_data;
        rsp_sbe_q  <= rd_en && dec_sbe;
        rsp_dbe_q  <= rd_en && dec_dbe;
      end
    end
  end

  // ---------------- memory command ----------------
  assign enc_in        = (state_q == ST_WR_ISSUE) ? merged : wdata_q;
  assign mem_cmd_valid = (state_q == ST_RD_ISSUE) || (state_q == ST_WR_ISSUE) ||
                         (state_q == ST_WR_PASS);
  assign mem_cmd_write = (state_q == ST_WR_ISSUE) || (state_q == ST_WR_PASS);
  assign mem_cmd_addr  = addr_q;
  assign mem_cmd_wdata = (state_q == ST_RD_ISSUE) ? '0 : enc_in;
  assign mem_cmd_ecc   = mem_cmd_write ? enc_chk : '0;
  assign mem_cmd_mask  = (state_q == ST_WR_PASS) ? ~be_q : '0;

  assign rsp_valid = rsp_valid_q;
  assign rsp_rdata = rsp_data_q;
  assign rsp_sbe   = rsp_sbe_q;
  assign rsp_dbe   = rsp_dbe_q;

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n_s)
    accept |=> !req_ready);  // R1
  AST_RMW_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_cmd_valid && mem_cmd_write && rmw_q) |-> (mem_cmd_mask == '0));  // R1
  AST_BUF_FILLED: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_cmd_valid && mem_cmd_write && rmw_q) |-> !buf_empty);  // R3
  AST_FLAGS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n_s)
    rsp_valid |-> !(rsp_sbe && rsp_dbe));  // R5
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_cmd_valid && !mem_cmd_ready) |=>
      (mem_cmd_valid && $stable(mem_cmd_addr) && $stable(mem_cmd_write)));  // R12
endmodule

// File: tb/tb_ecc_rmw_path.sv
`timescale 1ns/1ps
module tb_ecc_rmw_path;
  localparam int AW = 16;

  logic clk, rst_n;
  logic req_valid, req_ready, req_write;
  logic [AW-1:0] req_addr;
  logic [63:0] req_wdata;
  logic [7:0]  req_be;
  logic rsp_valid, rsp_sbe, rsp_dbe;
  logic [63:0] rsp_rdata;
  logic mem_cmd_valid, mem_cmd_ready, mem_cmd_write;
  logic [AW-1:0] mem_cmd_addr;
  logic [63:0] mem_cmd_wdata;
  logic [7:0]  mem_cmd_ecc, mem_cmd_mask;
  logic mem_rd_valid;
  logic [63:0] mem_rd_data;
  logic [7:0]  mem_rd_ecc;
  logic csr_we;
  logic [1:0] csr_addr;
  logic [7:0] csr_wdata, csr_rdata;
  logic irq;

  ecc_rmw_path #(.AW(AW)) dut (.*);

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  // memory model state: {ecc, data}
  logic [71:0] mem [16];
  logic [71:0] inj = '0;
  int  pos_tab [64];
  int  stall_n = 0, waited = 0, hold_viol = 0, busy_viol = 0, stall_seen = 0;
  bit  pend_rd = 0, was_stalled = 0, st_wr;
  logic [3:0]    pend_addr;
  logic [AW-1:0] st_addr;
  int  log_n = 0;
  logic          log_wr   [8];
  logic [AW-1:0] log_addr [8];
  logic [63:0]   log_data [8];
  logic [7:0]    log_ecc  [8];
  logic [7:0]    log_mask [8];

  function automatic logic [7:0] b_enc(input logic [63:0] d);
    logic [6:0] s = '0;
    for (int k = 0; k < 64; k++) if (d[k]) s ^= 7'(pos_tab[k]);
    return {(^d) ^ (^s), s};
  endfunction

  function automatic logic [63:0] b_merge(input logic [63:0] o, input logic [63:0] n, input logic [7:0] be);
    logic [63:0] r;
    for (int l = 0; l < 8; l++) r[8*l +: 8] = be[l] ? n[8*l +: 8] : o[8*l +: 8];
    return r;
  endfunction

  task automatic check(input string tag, input logic [71:0] act, input logic [71:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder
  initial begin
    mem_cmd_ready = 1'b0;
    mem_rd_valid  = 1'b0;
    mem_rd_data   = '0;
    mem_rd_ecc    = '0;
    forever begin
      @(negedge clk);
      if (pend_rd) begin
        mem_rd_valid = 1'b1;
        {mem_rd_ecc, mem_rd_data} = mem[pend_addr] ^ inj;
        pend_rd = 0;
      end else mem_rd_valid = 1'b0;
      if (was_stalled && !(mem_cmd_valid && mem_cmd_addr == st_addr && mem_cmd_write == st_wr))
        hold_viol++;
      if (mem_cmd_valid && req_ready) busy_viol++;
      if (mem_cmd_valid && waited < stall_n) begin mem_cmd_ready = 1'b0; waited++; end
      else mem_cmd_ready = 1'b1;
      #1;
      was_stalled = mem_cmd_valid && !mem_cmd_ready;
      if (was_stalled) begin st_addr = mem_cmd_addr; st_wr = mem_cmd_write; stall_seen++; end
      if (mem_cmd_valid && mem_cmd_ready) begin
        waited = 0;
        if (log_n < 8) begin
          log_wr[log_n] = mem_cmd_write;  log_addr[log_n] = mem_cmd_addr;
          log_data[log_n] = mem_cmd_wdata; log_ecc[log_n] = mem_cmd_ecc;
          log_mask[log_n] = mem_cmd_mask; log_n++;
        end
        if (mem_cmd_write) begin
          for (int l = 0; l < 8; l++)
            if (!mem_cmd_mask[l]) mem[mem_cmd_addr[3:0]][8*l +: 8] = mem_cmd_wdata[8*l +: 8];
          mem[mem_cmd_addr[3:0]][71:64] = mem_cmd_ecc;
        end else begin
          pend_rd = 1; pend_addr = mem_cmd_addr[3:0];
        end
      end
    end
  end

  task automatic do_op(input bit wr, input logic [3:0] a, input logic [63:0] d, input logic [7:0] be,
                       output logic [63:0] rd, output logic sb, output logic db);
    log_n = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = AW'(a); req_wdata = d; req_be = be;
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    req_valid = 1'b0;
    if (!wr) begin
      while (!rsp_valid) @(negedge clk);
      rd = rsp_rdata; sb = rsp_sbe; db = rsp_dbe;
    end else begin
      rd = '0; sb = 0; db = 0;
      #2;
      while (!req_ready) begin @(negedge clk); #2; end
    end
  endtask

  task automatic csr_wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_we = 1'b0;
  endtask

  task automatic csr_rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); csr_addr = a; #1; d = csr_rdata;
  endtask

  task automatic preload(input logic [3:0] a, input logic [63:0] d);
    mem[a] = {b_enc(d), d};
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      csr_rd(2'(a), v);
      check("R11 register reset value", 72'(v), 72'h0);
    end
    check("R9 irq low after reset", 72'(irq), 72'h0);
    check("R1 ready after reset", 72'(req_ready), 72'h1);
    check("R12 no command after reset", 72'(mem_cmd_valid), 72'h0);
  endtask

  task automatic t_plain_write;
    logic [63:0] r; logic s, b;
    do_op(1, 4'd5, 64'h1122334455667788, 8'h0F, r, s, b);
    check("R7 one command", 72'(log_n), 72'd1);
    check("R7 command is write", 72'(log_wr[0]), 72'h1);
    check("R7 mask is inverted enables", 72'(log_mask[0]), 72'hF0);
    check("R7 write data", 72'(log_data[0]), 72'h1122334455667788);
  endtask

  task automatic t_ctrl;
    logic [7:0] v;
    csr_wr(2'd0, 8'h03);
    csr_rd(2'd0, v);  check("R11 control readback", 72'(v), 72'h03);
    csr_rd(2'd3, v);  check("R11 spare address reads zero", 72'(v), 72'h0);
  endtask

  task automatic t_rmw(input logic [63:0] a, input logic [63:0] b, input logic [7:0] be, input string tag);
    logic [63:0] r, m; logic s, d;
    preload(4'd2, a);
    do_op(1, 4'd2, b, be, r, s, d);
    m = b_merge(a, b, be);
    check({tag, " R1 two commands"}, 72'(log_n), 72'd2);
    check({tag, " R1 read first"}, 72'({log_wr[0], log_addr[0]}), 72'({1'b0, 16'd2}));
    check({tag, " R1 then write same address"}, 72'({log_wr[1], log_addr[1]}), 72'({1'b1, 16'd2}));
    check({tag, " R1 write unmasked"}, 72'(log_mask[1]), 72'h0);
    check({tag, " R2 merged data"}, 72'(log_data[1]), 72'(m));
    check({tag, " R3 R4 check bits of merged word"}, 72'(log_ecc[1]), 72'(b_enc(m)));
  endtask

  task automatic t_rmw_sbe;
    logic [63:0] r; logic s, d; logic [7:0] v;
    csr_wr(2'd1, 8'hFF);
    preload(4'd3, 64'hA5A5_0000_FFFF_1234);
    inj = 72'h1 << 3;
    do_op(1, 4'd3, 64'hDEAD_BEEF_0000_0000, 8'hF0, r, s, d);
    inj = '0;
    check("R2 corrected lanes merged", 72'(log_data[1]), 72'hDEAD_BEEF_FFFF_1234);
    csr_rd(2'd1, v); check("R8 single count after RMW", 72'(v), 72'd1);
  endtask

  task automatic t_read;
    logic [63:0] r, w; logic s, d; logic [7:0] v;
    csr_wr(2'd1, 8'hFF); csr_wr(2'd2, 8'hFF);
    w = 64'h0123_4567_89AB_CDEF;
    preload(4'd7, w);
    do_op(0, 4'd7, '0, '0, r, s, d);
    check("R5 clean read", 72'({s, d, r}), 72'({2'b00, w}));
    inj = 72'h1 << 40;
    do_op(0, 4'd7, '0, '0, r, s, d);
    check("R5 data bit corrected", 72'({s, d, r}), 72'({2'b10, w}));
    inj = 72'h1 << 66;
    do_op(0, 4'd7, '0, '0, r, s, d);
    check("R5 check bit error flagged", 72'({s, d, r}), 72'({2'b10, w}));
    inj = (72'h1 << 5) | (72'h1 << 9);
    do_op(0, 4'd7, '0, '0, r, s, d);
    check("R5 double error raw data", 72'({s, d, r}), 72'({2'b01, w ^ 64'h220}));
    inj = '0;
    csr_rd(2'd1, v); check("R8 single count", 72'(v), 72'd2);
    csr_rd(2'd2, v); check("R8 double count", 72'(v), 72'd1);
  endtask

  task automatic t_irq;
    check("R9 irq held off with enables clear", 72'(irq), 72'h0);
    csr_wr(2'd0, 8'h07); #1;
    check("R9 single enable raises irq", 72'(irq), 72'h1);
    csr_wr(2'd1, 8'hFF); #1;
    check("R9 cleared single count drops irq", 72'(irq), 72'h0);
    csr_wr(2'd0, 8'h0B); #1;
    check("R9 double enable raises irq", 72'(irq), 72'h1);
    csr_wr(2'd2, 8'hFF); #1;
    check("R8 write ones clears, irq low", 72'(irq), 72'h0);
    csr_wr(2'd0, 8'h03);
  endtask

  task automatic t_rmw_dbe;
    logic [63:0] r, a; logic s, d; logic [7:0] v;
    a = 64'h0F0F_0F0F_3C3C_5A5A;
    preload(4'd4, a);
    inj = 72'h3;
    do_op(1, 4'd4, 64'h9999_8888_0000_0000, 8'hF0, r, s, d);
    inj = '0;
    check("R10 write still issued", 72'({log_wr[1], log_mask[1]}), 72'({1'b1, 8'h00}));
    check("R10 raw bytes kept", 72'(log_data[1]), 72'({32'h9999_8888, a[31:0] ^ 32'h3}));
    csr_rd(2'd2, v); check("R10 double count", 72'(v), 72'd1);
    csr_wr(2'd2, 8'hFF);
  endtask

  task automatic t_rd_off;
    logic [63:0] r, w; logic s, d; logic [7:0] v;
    csr_wr(2'd0, 8'h02);
    w = 64'hCAFE_F00D_1357_9BDF;
    preload(4'd9, w);
    inj = 72'h1 << 12;
    do_op(0, 4'd9, '0, '0, r, s, d);
    inj = '0;
    check("R6 raw data, no flags", 72'({s, d, r}), 72'({2'b00, w ^ 64'h1000}));
    csr_rd(2'd1, v); check("R6 counter unchanged", 72'(v), 72'd0);
    csr_wr(2'd0, 8'h03);
  endtask

  task automatic t_sat;
    logic [63:0] r; logic s, d; logic [7:0] v;
    preload(4'd6, 64'h5555_AAAA_5555_AAAA);
    inj = 72'h1 << 20;
    for (int i = 0; i < 260; i++) do_op(0, 4'd6, '0, '0, r, s, d);
    inj = '0;
    csr_rd(2'd1, v); check("R8 saturates at 255", 72'(v), 72'd255);
    csr_wr(2'd1, 8'h0F);
    csr_rd(2'd1, v); check("R8 partial clear", 72'(v), 72'hF0);
    csr_wr(2'd1, 8'hFF);
  endtask

  task automatic t_stall;
    logic [63:0] r; logic s, d;
    stall_n = 3;
    t_rmw(64'h1111_2222_3333_4444, 64'hAAAA_BBBB_CCCC_DDDD, 8'h3C, "stall");
    preload(4'd8, 64'h7777_6666_5555_4444);
    do_op(0, 4'd8, '0, '0, r, s, d);
    check("R12 stalled read data", 72'(r), 72'h7777_6666_5555_4444);
    stall_n = 0;
    check("R12 command held while stalled", 72'(hold_viol), 72'd0);
    check("R12 stalls occurred", 72'(stall_seen > 0), 72'h1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    begin
      int n = 0;
      for (int p = 1; p < 72; p++) if ((p & (p - 1)) != 0) begin pos_tab[n] = p; n++; end
    end
    for (int i = 0; i < 16; i++) mem[i] = '0;
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0; req_be = '0;
    csr_we = 1'b0; csr_addr = '0; csr_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_plain_write();
    t_ctrl();
    t_rmw(64'h0011_2233_4455_6677, 64'hFFEE_DDCC_BBAA_9988, 8'h5A, "partial");
    t_rmw(64'h0BAD_0BAD_0BAD_0BAD, 64'h1234_5678_9ABC_DEF0, 8'hFF, "full");
    t_rmw_sbe();
    t_read();
    t_irq();
    t_rmw_dbe();
    t_rd_off();
    t_sat();
    t_stall();
    check("R1 no request accepted during a command", 72'(busy_viol), 72'd0);
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule